// File: doc/BRIEF.md
# DMA Request Guard with Underrun Lockout

This block sits beside each converter channel and turns that channel's hardware trigger into a DMA request. When DMA service is enabled for the channel and a hardware trigger fires, the block raises one request and holds it until the DMA controller acknowledges it. Requests are never queued. If another hardware trigger arrives while the request is still unacknowledged, the block does not issue a second request. Instead it records an underrun.

An underrun sets a sticky per-channel error flag. It withdraws the outstanding request and locks the channel out of any further requests. The converter itself keeps running on the data it already holds. Software reads the flag and clears it by writing a one. An interrupt line follows the flag whenever the channel's interrupt enable is set. Requests resume only after a deliberate recovery: the flag must be cleared and DMA enable must be toggled off and back on. The number of channels is a parameter, and every channel works independently of the others.

Top module: `dma_req_guard`

## Requirements
- R1: After reset, every request, underrun flag and interrupt output is low.
- R2: A hardware trigger pulse on a channel that has DMA enable set, is not locked out and has no outstanding request drives that channel's request high on the next clock.
- R3: A trigger pulse marked as software-originated (swTrig high in the same cycle) never raises a request and never causes an underrun.
- R4: While DMA enable is low, hardware triggers raise no request.
- R5: A raised request stays high until the acknowledge is seen, and goes low on the clock after the acknowledge if no new trigger arrives in that cycle.
- R6: A hardware trigger that arrives while the request is high and unacknowledged sets the underrun flag on the next clock and withdraws the request in the same clock.
- R7: A hardware trigger in the same cycle as the acknowledge starts a fresh request: the request stays high and no underrun is flagged.
- R8: While the channel is locked out after an underrun, hardware triggers raise no request and acknowledges have no effect.
- R9: The underrun flag stays set until a one is written to the channel's clear strobe, and is low on the next clock after that write. Cycles with the clear strobe at 0 leave it set. If an underrun and a clear happen in the same cycle, the underrun wins.
- R10: The interrupt output equals the underrun flag ANDed with the channel's interrupt enable, in the same cycle.
- R11: Clearing the flag alone does not end the lockout. The lockout ends on the first clock where DMA enable is high, the flag is clear, and DMA enable has been low at some earlier clock since the underrun. From then on, triggers raise requests again.
- R12: Each channel's request, flag, lockout and interrupt depend only on that channel's own inputs.
- R13: Dropping DMA enable while a request is outstanding withdraws the request on the next clock without flagging an underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hwTrig | input | NCH | One-cycle trigger pulse per channel |
| swTrig | input | NCH | Marks the current trigger pulse as software-originated |
| dmaEn | input | NCH | DMA service enable per channel |
| udrIntEn | input | NCH | Underrun interrupt enable per channel |
| dmaAck | input | NCH | One-cycle acknowledge from the DMA controller |
| udrClr | input | NCH | Write-one-to-clear strobe for the underrun flag |
| dmaReq | output | NCH | Request to the DMA controller |
| udrFlag | output | NCH | Sticky underrun flag |
| udrIrq | output | NCH | Underrun interrupt |

## Verification
The bench builds the block with NCH set to 2. The second channel makes it possible to check that a locked, flagged channel leaves its neighbour's request path and interrupt untouched, and that a clear strobe on one channel does not reach the other. With two channels, overlapping and coinciding trigger/acknowledge patterns on channel 0 can be checked while channel 1 holds a different state.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  // Per-channel update strobes sent from control to datapath.
  typedef struct packed {
    logic reqSet;   // start a new request
    logic reqClr;   // retire or withdraw the request
    logic udrSet;   // underrun detected this cycle
    logic udrClr;   // software clear of the underrun flag
    logic lockSet;  // enter lockout
    logic armSet;   // enable seen low while locked
    logic lockClr;  // leave lockout
  } strobe_t;

endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] hwTrig,
  input  logic [NCH-1:0] swTrig,
  input  logic [NCH-1:0] dmaEn,
  input  logic [NCH-1:0] dmaAck,
  input  logic [NCH-1:0] udrClr,
  input  logic [NCH-1:0] reqQ,
  input  logic [NCH-1:0] flagQ,
  input  logic [NCH-1:0] lockQ,
  input  logic [NCH-1:0] armQ,
  output strobe_t        stb [NCH]
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hwEvt;
    logic overlap;

    // Only a hardware-originated trigger on an enabled, unlocked channel counts.
    assign hwEvt   = hwTrig[ch] & ~swTrig[ch] & dmaEn[ch] & ~lockQ[ch];
    // A counted trigger collides when the previous request is still unacknowledged.
    assign overlap = hwEvt & reqQ[ch] & ~dmaAck[ch];

    always_comb begin
      stb[ch]         = '0;
      stb[ch].reqSet  = hwEvt & ~overlap;
      stb[ch].reqClr  = reqQ[ch] & (dmaAck[ch] | ~dmaEn[ch] | overlap);
      stb[ch].udrSet  = overlap;
      stb[ch].udrClr  = udrClr[ch];
      stb[ch].lockSet = overlap;
      stb[ch].armSet  = lockQ[ch] & ~dmaEn[ch];
      stb[ch].lockClr = lockQ[ch] & armQ[ch] & dmaEn[ch] & ~flagQ[ch];
    end
  end

endmodule

// File: rtl/dma_req_dpath.sv
module dma_req_dpath
  import dma_req_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        stb [NCH],
  input  logic [NCH-1:0] udrIntEn,
  output logic [NCH-1:0] reqQ,
  output logic [NCH-1:0] flagQ,
  output logic [NCH-1:0] lockQ,
  output logic [NCH-1:0] armQ,
  output logic [NCH-1:0] irq
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqQ[ch]  <= 1'b0;
        flagQ[ch] <= 1'b0;
        lockQ[ch] <= 1'b0;
        armQ[ch]  <= 1'b0;
      end else begin
        // A new request has priority over retiring the old one.
        if (stb[ch].reqSet)       reqQ[ch] <= 1'b1;
        else if (stb[ch].reqClr)  reqQ[ch] <= 1'b0;

        // A new underrun has priority over a software clear.
        if (stb[ch].udrSet)       flagQ[ch] <= 1'b1;
        else if (stb[ch].udrClr)  flagQ[ch] <= 1'b0;

        if (stb[ch].lockSet)      lockQ[ch] <= 1'b1;
        else if (stb[ch].lockClr) lockQ[ch] <= 1'b0;

        if (stb[ch].lockSet || stb[ch].lockClr) armQ[ch] <= 1'b0;
        else if (stb[ch].armSet)                armQ[ch] <= 1'b1;
      end
    end

    assign irq[ch] = flagQ[ch] & udrIntEn[ch];
  end

endmodule

// File: rtl/dma_req_guard.sv
module dma_req_guard
  import dma_req_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] hwTrig,
  input  logic [NCH-1:0] swTrig,
  input  logic [NCH-1:0] dmaEn,
  input  logic [NCH-1:0] udrIntEn,
  input  logic [NCH-1:0] dmaAck,
  input  logic [NCH-1:0] udrClr,
  output logic [NCH-1:0] dmaReq,
  output logic [NCH-1:0] udrFlag,
  output logic [NCH-1:0] udrIrq
);

  strobe_t        stb [NCH];
  logic [NCH-1:0] reqQ;
  logic [NCH-1:0] flagQ;
  logic [NCH-1:0] lockQ;
  logic [NCH-1:0] armQ;

  dma_req_ctrl #(.NCH(NCH)) u_ctrl (
    .hwTrig (hwTrig),
    .swTrig (swTrig),
    .dmaEn  (dmaEn),
    .dmaAck (dmaAck),
    .udrClr (udrClr),
    .reqQ   (reqQ),
    .flagQ  (flagQ),
    .lockQ  (lockQ),
    .armQ   (armQ),
    .stb    (stb)
  );

  dma_req_dpath #(.NCH(NCH)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .udrIntEn (udrIntEn),
    .reqQ     (reqQ),
    .flagQ    (flagQ),
    .lockQ    (lockQ),
    .armQ     (armQ),
    .irq      (udrIrq)
  );

  assign dmaReq  = reqQ;
  assign udrFlag = flagQ;

endmodule

// File: rtl/dma_req_guard_chk.sv
module dma_req_guard_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic [NCH-1:0] hwTrig,
  input logic [NCH-1:0] swTrig,
  input logic [NCH-1:0] dmaEn,
  input logic [NCH-1:0] udrIntEn,
  input logic [NCH-1:0] dmaAck,
  input logic [NCH-1:0] udrClr,
  input logic [NCH-1:0] dmaReq,
  input logic [NCH-1:0] udrFlag,
  input logic [NCH-1:0] udrIrq
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    // R3: an idle channel with no hardware-originated trigger stays idle
    a_r3_sw_no_req: assert property (@(posedge clk) disable iff (!rstN)
      (!dmaReq[ch] && (swTrig[ch] || !hwTrig[ch])) |=> !dmaReq[ch]);

    // R4 / R13: with DMA disabled, no request survives to the next clock
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
      !dmaEn[ch] |=> !dmaReq[ch]);

    // R5: acknowledge without a new trigger retires the request
    a_r5_ack_drop: assert property (@(posedge clk) disable iff (!rstN)
      (dmaReq[ch] && dmaAck[ch] && !hwTrig[ch]) |=> !dmaReq[ch]);

    // R5: an unacknowledged request is held while enabled and quiet
    a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
      (dmaReq[ch] && !dmaAck[ch] && dmaEn[ch] && !hwTrig[ch]) |=> dmaReq[ch]);

    // R6: overlapping hardware trigger flags underrun and withdraws request
    a_r6_overlap: assert property (@(posedge clk) disable iff (!rstN)
      (dmaReq[ch] && hwTrig[ch] && !swTrig[ch] && dmaEn[ch] && !dmaAck[ch])
        |=> (udrFlag[ch] && !dmaReq[ch]));

    // R6: the flag only rises after a trigger met an outstanding request
    a_r6_cause: assert property (@(posedge clk) disable iff (!rstN)
      $rose(udrFlag[ch]) |-> $past(dmaReq[ch] && hwTrig[ch]));

    // R7: trigger coinciding with acknowledge keeps the request, no underrun
    a_r7_ack_retrigger: assert property (@(posedge clk) disable iff (!rstN)
      (dmaReq[ch] && dmaAck[ch] && hwTrig[ch] && !swTrig[ch] && dmaEn[ch] && !udrFlag[ch])
        |=> (dmaReq[ch] && !udrFlag[ch]));

    // R9: the flag is sticky until a clear strobe
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (udrFlag[ch] && !udrClr[ch]) |=> udrFlag[ch]);
  end

endmodule

bind dma_req_guard dma_req_guard_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_dma_req_guard.sv
`timescale 1ns/1ps
module sim_dma_req_guard;

  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] hwTrig = '0;
  logic [NCH-1:0] swTrig = '0;
  logic [NCH-1:0] dmaEn = '0;
  logic [NCH-1:0] udrIntEn = '0;
  logic [NCH-1:0] dmaAck = '0;
  logic [NCH-1:0] udrClr = '0;
  logic [NCH-1:0] dmaReq;
  logic [NCH-1:0] udrFlag;
  logic [NCH-1:0] udrIrq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_req_guard #(.NCH(NCH)) u0 (
    .clk(clk), .rstN(rstN), .hwTrig(hwTrig), .swTrig(swTrig), .dmaEn(dmaEn),
    .udrIntEn(udrIntEn), .dmaAck(dmaAck), .udrClr(udrClr),
    .dmaReq(dmaReq), .udrFlag(udrFlag), .udrIrq(udrIrq)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive the given pulses for one cycle, then return them to zero.
  task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] a,
                       input logic [NCH-1:0] c);
    hwTrig = t; dmaAck = a; udrClr = c;
    cyc();
    hwTrig = '0; dmaAck = '0; udrClr = '0;
  endtask

  task automatic t_reset();
    chk("R1 req", dmaReq, 0);
    chk("R1 flag", udrFlag, 0);
    chk("R1 irq", udrIrq, 0);
  endtask

  task automatic t_basic();
    pulse(2'b01, 2'b00, 2'b00);
    chk("R2 req raised", dmaReq, 2'b01);
    cyc(); cyc(); cyc();
    chk("R5 req held", dmaReq, 2'b01);
    pulse(2'b00, 2'b01, 2'b00);
    chk("R5 req dropped after ack", dmaReq, 2'b00);
  endtask

  task automatic t_sw();
    swTrig = 2'b01;
    pulse(2'b01, 2'b00, 2'b00);
    swTrig = 2'b00;
    chk("R3 sw trigger no req", dmaReq, 0);
    chk("R3 sw trigger no flag", udrFlag, 0);
  endtask

  task automatic t_noen();
    dmaEn[0] = 1'b0;
    pulse(2'b01, 2'b00, 2'b00);
    chk("R4 disabled no req", dmaReq, 0);
    dmaEn[0] = 1'b1;
  endtask

  task automatic t_withdraw();
    pulse(2'b01, 2'b00, 2'b00);
    chk("R13 req up", dmaReq, 2'b01);
    dmaEn[0] = 1'b0;
    cyc();
    chk("R13 req withdrawn", dmaReq, 0);
    chk("R13 no underrun", udrFlag, 0);
    dmaEn[0] = 1'b1;
    cyc();
  endtask

  task automatic t_coincide();
    pulse(2'b01, 2'b00, 2'b00);
    pulse(2'b01, 2'b01, 2'b00);
    chk("R7 req kept", dmaReq, 2'b01);
    chk("R7 no underrun", udrFlag, 0);
    pulse(2'b00, 2'b01, 2'b00);
    chk("R7 req retired", dmaReq, 0);
  endtask

  task automatic t_underrun();
    pulse(2'b01, 2'b00, 2'b00);
    pulse(2'b01, 2'b00, 2'b00);
    chk("R6 flag set", udrFlag, 2'b01);
    chk("R6 req withdrawn", dmaReq, 0);
    chk("R10 irq masked", udrIrq, 0);
    udrIntEn = 2'b01;
    #1;
    chk("R10 irq follows enable", udrIrq, 2'b01);
    chk("R12 other channel clean", udrFlag[1], 0);
  endtask

  task automatic t_locked();
    pulse(2'b01, 2'b00, 2'b00);
    chk("R8 locked no req", dmaReq, 0);
    pulse(2'b00, 2'b01, 2'b00);
    chk("R8 ack ignored", dmaReq, 0);
    cyc(); cyc();
    chk("R9 flag sticky with clear at 0", udrFlag, 2'b01);
  endtask

  task automatic t_recover();
    pulse(2'b00, 2'b00, 2'b01);
    chk("R9 flag cleared", udrFlag, 0);
    chk("R10 irq cleared", udrIrq, 0);
    pulse(2'b01, 2'b00, 2'b00);
    chk("R11 still locked after clear", dmaReq, 0);
    dmaEn[0] = 1'b0;
    cyc();
    dmaEn[0] = 1'b1;
    cyc();
    pulse(2'b01, 2'b00, 2'b00);
    chk("R11 req after release", dmaReq, 2'b01);
    pulse(2'b00, 2'b01, 2'b00);
    chk("R11 req retired", dmaReq, 0);
  endtask

  task automatic t_setwins();
    udrIntEn = 2'b10;
    pulse(2'b10, 2'b00, 2'b00);
    chk("R2 ch1 req", dmaReq, 2'b10);
    pulse(2'b10, 2'b00, 2'b10);
    chk("R9 set wins over clear", udrFlag, 2'b10);
    chk("R12 ch1 irq only", udrIrq, 2'b10);
    pulse(2'b01, 2'b00, 2'b00);
    chk("R12 ch0 unaffected", dmaReq, 2'b01);
    pulse(2'b00, 2'b01, 2'b01);
    chk("R12 ch0 clear leaves ch1", udrFlag, 2'b10);
    chk("R5 ch0 retired", dmaReq, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rstN = 1'b1;
    cyc();
    t_reset();
    dmaEn = 2'b11;
    cyc();
    t_basic();
    t_sw();
    t_noen();
    t_withdraw();
    t_coincide();
    t_underrun();
    t_locked();
    t_recover();
    t_setwins();
    cyc();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule